// File: doc/BRIEF.md
# Legacy Keyboard Trap and SMI Controller

This block holds the 16-bit legacy-support control and status word of a USB host controller, together with the event logic behind it. It watches every host I/O access and records reads and writes to the keyboard-controller data port (60h) and command port (64h) in sticky flags. Software clears these flags by writing ones to them. Each of the four access kinds has its own trap enable. An enabled access raises a one-cycle trap indication in the same cycle. A recorded flag whose enable is set holds the active-low system-management interrupt output low.

Two more sources can pull that output low. The USB interrupt line does so when its SMI gate is on. The end of an A20 gate passthrough sequence does so when its own enable is set; that sequence is modelled as an "in progress" level and an "ended" pulse from an external sequencer. The USB interrupt also goes to a PIRQD request output, which a routing bit can turn off. The word sits at configuration byte offset C0h and is reached through a simple read/write port with two byte enables.

Top module: `kbd_legacy_ctl`

## Requirements
- R1: After reset the word reads 0x2000 with usb_irq and a20_active low, smi_n is high, and pirqd_irq is low.
- R2: An access sets one flag: read of 60h sets bit 8, write of 60h sets bit 9, read of 64h sets bit 10, write of 64h sets bit 11. The flag stays set, and an access to any other port sets nothing.
- R3: Writing a 1 to a flag bit (8 to 11, or 15) with the high byte enabled clears it. Writing 0 leaves it unchanged.
- R4: If an access event and a clearing write for the same flag fall in the same cycle, the flag stays set.
- R5: Bits 0 to 3 enable trapping for the flags of bits 8 to 11 in the same order. smi_n is low while any flag has its enable set, and high once none does.
- R6: Bit 12 reads the live usb_irq level. With bit 4 set, an active usb_irq drives smi_n low.
- R7: pirqd_irq equals usb_irq while bit 13 is set and stays low while bit 13 is clear.
- R8: Bit 5 drives a20_pass_en. Bit 6 reads a20_active AND bit 5. An a20_end pulse sets bit 15 only while bit 5 is set. Bit 15 together with bit 7 drives smi_n low.
- R9: Writes to bits 6, 12 and 14 are ignored, and bit 14 always reads 0.
- R10: cfg_be[0] gates writes to bits 7:0 and cfg_be[1] gates writes to bits 15:8.
- R11: A write to any offset other than C0h changes nothing, and a read there returns 0.
- R12: io_trap is high in the cycle of an access whose enable bit (0 to 3) is set, and low otherwise.
- R13: Writing 0x2000 leaves routing on and every SMI source off. Writing all ones reads back 0x20BF, whose 0x00BF mask marks legacy support as enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_we | input | 1 | Write strobe |
| cfg_be | input | 2 | Byte enables (bit 0 low byte, bit 1 high byte) |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data, combinational, zero when the offset misses |
| io_valid | input | 1 | Host I/O access in this cycle |
| io_write | input | 1 | 1 for write access, 0 for read access |
| io_port | input | 16 | I/O port address of the access |
| io_trap | output | 1 | Enabled keyboard-port access trapped this cycle |
| usb_irq | input | 1 | USB interrupt level from the host controller |
| a20_active | input | 1 | A20 passthrough sequence in progress |
| a20_end | input | 1 | One-cycle pulse when the sequence ends |
| a20_pass_en | output | 1 | Passthrough enable to the sequencer |
| smi_n | output | 1 | Active-low system-management interrupt |
| pirqd_irq | output | 1 | Routed USB interrupt request |

## Verification
A wrong flag or enable state shows up on smi_n and in the read word one clock after the access or write that caused it. A flag that fails to set, or fails to clear, therefore appears at the next read. Priority errors show in the cycle after a collision between an event and a clear: the flag reads back cleared when it should stay set. Routing and USB-gate faults appear combinationally on pirqd_irq and smi_n as soon as usb_irq changes. The bench therefore checks those outputs in the same cycle as the usb_irq change.

// File: rtl/kbd_legacy_pkg.sv
package kbd_legacy_pkg;

  localparam int REG_W     = 16;
  localparam int NUM_TRAPS = 4;

  // bit positions of the legacy-support word
  localparam int B_TRAP_EN   = 0;   // 4 enables, bits 3:0
  localparam int B_USB_SMI   = 4;
  localparam int B_A20_EN    = 5;
  localparam int B_A20_BUSY  = 6;
  localparam int B_A20_SMI   = 7;
  localparam int B_TRAP_FLAG = 8;   // 4 flags, bits 11:8
  localparam int B_USB_IRQ   = 12;
  localparam int B_RSVD      = 14;
  localparam int B_PIRQ_RT   = 13;
  localparam int B_A20_END   = 15;

  localparam logic [REG_W-1:0] RESET_WORD = 16'h2000;

  typedef struct packed {
    logic [NUM_TRAPS-1:0] trap_en;
    logic                 usb_smi_en;
    logic                 a20_en;
    logic                 a20_smi_en;
    logic                 pirq_route;
  } ctl_t;

endpackage

// File: rtl/kbd_port_watch.sv
module kbd_port_watch
  import kbd_legacy_pkg::*;
#(
  parameter int               PORT_W    = 16,
  parameter logic [PORT_W-1:0] DATA_PORT = 16'h0060,
  parameter logic [PORT_W-1:0] CMD_PORT  = 16'h0064
) (
  input  logic                 io_valid,
  input  logic                 io_write,
  input  logic [PORT_W-1:0]    io_port,
  output logic [NUM_TRAPS-1:0] acc_ev
);

  // event order: data read, data write, command read, command write
  for (genvar i = 0; i < NUM_TRAPS; i++) begin : g_ev
    localparam logic [PORT_W-1:0] PORT_SEL = (i < 2) ? DATA_PORT : CMD_PORT;
    localparam logic              WR_SEL   = (i % 2) == 1;
    always_comb begin
      acc_ev[i] = io_valid && (io_port == PORT_SEL) && (io_write == WR_SEL);
    end
  end

endmodule

// File: rtl/kbd_sticky_flag.sv
module kbd_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  logic q_d;

  // a new event outranks a clear in the same cycle
  always_comb begin
    q_d = q_o;
    if (clr_i) q_d = 1'b0;
    if (set_i) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_d;
  end

endmodule

// File: rtl/kbd_smi_combine.sv
module kbd_smi_combine
  import kbd_legacy_pkg::*;
(
  input  logic [NUM_TRAPS-1:0] trap_flag,
  input  logic [NUM_TRAPS-1:0] trap_en,
  input  logic                 usb_irq,
  input  logic                 usb_smi_en,
  input  logic                 a20_end_flag,
  input  logic                 a20_smi_en,
  output logic                 smi_n_o
);

  logic trap_src, usb_src, a20_src;

  always_comb begin
    trap_src = |(trap_flag & trap_en);
    usb_src  = usb_irq && usb_smi_en;
    a20_src  = a20_end_flag && a20_smi_en;
    smi_n_o  = !(trap_src || usb_src || a20_src);
  end

endmodule

// File: rtl/kbd_legacy_ctl.sv
module kbd_legacy_ctl
  import kbd_legacy_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET  = 8'hC0,
  parameter int                PORT_W      = 16,
  parameter logic [PORT_W-1:0] DATA_PORT   = 16'h0060,
  parameter logic [PORT_W-1:0] CMD_PORT    = 16'h0064,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_be,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              io_valid,
  input  logic              io_write,
  input  logic [PORT_W-1:0] io_port,
  output logic              io_trap,
  input  logic              usb_irq,
  input  logic              a20_active,
  input  logic              a20_end,
  output logic              a20_pass_en,
  output logic              smi_n,
  output logic              pirqd_irq
);

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  // write decode
  logic reg_hit, wr_lo, wr_hi;
  always_comb begin
    reg_hit = (cfg_addr == REG_OFFSET);
    wr_lo   = cfg_we && reg_hit && cfg_be[0];
    wr_hi   = cfg_we && reg_hit && cfg_be[1];
  end

  // read/write control bits
  ctl_t ctl_q, ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_lo) begin
      ctl_d.trap_en    = cfg_wdata[B_TRAP_EN +: NUM_TRAPS];
      ctl_d.usb_smi_en = cfg_wdata[B_USB_SMI];
      ctl_d.a20_en     = cfg_wdata[B_A20_EN];
      ctl_d.a20_smi_en = cfg_wdata[B_A20_SMI];
    end
    if (wr_hi) begin
      ctl_d.pirq_route = cfg_wdata[B_PIRQ_RT];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctl_q.trap_en    <= RESET_WORD[B_TRAP_EN +: NUM_TRAPS];
      ctl_q.usb_smi_en <= RESET_WORD[B_USB_SMI];
      ctl_q.a20_en     <= RESET_WORD[B_A20_EN];
      ctl_q.a20_smi_en <= RESET_WORD[B_A20_SMI];
      ctl_q.pirq_route <= RESET_WORD[B_PIRQ_RT];
    end else begin
      ctl_q <= ctl_d;
    end
  end

  // access detection
  logic [NUM_TRAPS-1:0] acc_ev;

  kbd_port_watch #(
    .PORT_W   (PORT_W),
    .DATA_PORT(DATA_PORT),
    .CMD_PORT (CMD_PORT)
  ) u_watch (
    .io_valid(io_valid),
    .io_write(io_write),
    .io_port (io_port),
    .acc_ev  (acc_ev)
  );

  // sticky access flags
  logic [NUM_TRAPS-1:0] trap_flag_q;

  for (genvar i = 0; i < NUM_TRAPS; i++) begin : g_flag
    kbd_sticky_flag u_flag (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .set_i(acc_ev[i]),
      .clr_i(wr_hi && cfg_wdata[B_TRAP_FLAG + i]),
      .q_o  (trap_flag_q[i])
    );
  end

  // passthrough-ended flag
  logic a20_end_q;

  kbd_sticky_flag u_a20_flag (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .set_i(a20_end && ctl_q.a20_en),
    .clr_i(wr_hi && cfg_wdata[B_A20_END]),
    .q_o  (a20_end_q)
  );

  // SMI merge
  kbd_smi_combine u_smi (
    .trap_flag   (trap_flag_q),
    .trap_en     (ctl_q.trap_en),
    .usb_irq     (usb_irq),
    .usb_smi_en  (ctl_q.usb_smi_en),
    .a20_end_flag(a20_end_q),
    .a20_smi_en  (ctl_q.a20_smi_en),
    .smi_n_o     (smi_n)
  );

  // outputs
  logic [REG_W-1:0] word;

  always_comb begin
    word                                = '0;
    word[B_TRAP_EN +: NUM_TRAPS]        = ctl_q.trap_en;
    word[B_USB_SMI]                     = ctl_q.usb_smi_en;
    word[B_A20_EN]                      = ctl_q.a20_en;
    word[B_A20_BUSY]                    = a20_active && ctl_q.a20_en;
    word[B_A20_SMI]                     = ctl_q.a20_smi_en;
    word[B_TRAP_FLAG +: NUM_TRAPS]      = trap_flag_q;
    word[B_USB_IRQ]                     = usb_irq;
    word[B_PIRQ_RT]                     = ctl_q.pirq_route;
    word[B_RSVD]                        = 1'b0;
    word[B_A20_END]                     = a20_end_q;
    cfg_rdata   = reg_hit ? word : '0;
    io_trap     = |(acc_ev & ctl_q.trap_en);
    a20_pass_en = ctl_q.a20_en;
    pirqd_irq   = usb_irq && ctl_q.pirq_route;
  end

endmodule

// File: rtl/kbd_legacy_chk.sv
module kbd_legacy_chk
  import kbd_legacy_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'hC0,
  parameter int                PORT_W     = 16,
  parameter logic [PORT_W-1:0] DATA_PORT  = 16'h0060
) (
  input logic                 clk,
  input logic                 rst_sync_n,
  input logic [ADDR_W-1:0]    cfg_addr,
  input logic                 cfg_we,
  input logic [1:0]           cfg_be,
  input logic [REG_W-1:0]     cfg_wdata,
  input logic [REG_W-1:0]     cfg_rdata,
  input logic                 io_valid,
  input logic                 io_write,
  input logic [PORT_W-1:0]    io_port,
  input logic                 usb_irq,
  input logic                 a20_end,
  input logic                 smi_n,
  input logic                 pirqd_irq,
  input logic [NUM_TRAPS-1:0] trap_flag_q,
  input logic [NUM_TRAPS-1:0] trap_en,
  input logic                 usb_smi_en,
  input logic                 a20_end_q
);

  logic clr_rd60, ev_rd60;
  always_comb begin
    clr_rd60 = cfg_we && (cfg_addr == REG_OFFSET) && cfg_be[1] && cfg_wdata[B_TRAP_FLAG];
    ev_rd60  = io_valid && !io_write && (io_port == DATA_PORT);
  end

  // R2: a set flag holds until cleared
  a_r2_flag_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap_flag_q[0] && !clr_rd60 |=> trap_flag_q[0]);

  // R4: event outranks a same-cycle clear
  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ev_rd60 && clr_rd60 |=> trap_flag_q[0]);

  // R5: an enabled flag pulls SMI low
  a_r5_trap_smi: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|(trap_flag_q & trap_en)) |-> !smi_n);

  // R6: gated USB interrupt pulls SMI low
  a_r6_usb_smi: assert property (@(posedge clk) disable iff (!rst_sync_n)
    usb_irq && usb_smi_en |-> !smi_n);

  // R7: no routed request without the USB interrupt
  a_r7_pirq_src: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pirqd_irq |-> usb_irq);

  // R8: end flag rises only after an end pulse
  a_r8_end_cause: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(a20_end_q) |-> $past(a20_end));

  // R9: reserved bit stays zero
  a_r9_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_rdata[B_RSVD] == 1'b0);

endmodule

bind kbd_legacy_ctl kbd_legacy_chk #(
  .ADDR_W    (ADDR_W),
  .REG_OFFSET(REG_OFFSET),
  .PORT_W    (PORT_W),
  .DATA_PORT (DATA_PORT)
) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cfg_addr   (cfg_addr),
  .cfg_we     (cfg_we),
  .cfg_be     (cfg_be),
  .cfg_wdata  (cfg_wdata),
  .cfg_rdata  (cfg_rdata),
  .io_valid   (io_valid),
  .io_write   (io_write),
  .io_port    (io_port),
  .usb_irq    (usb_irq),
  .a20_end    (a20_end),
  .smi_n      (smi_n),
  .pirqd_irq  (pirqd_irq),
  .trap_flag_q(trap_flag_q),
  .trap_en    (ctl_q.trap_en),
  .usb_smi_en (ctl_q.usb_smi_en),
  .a20_end_q  (a20_end_q)
);

// File: tb/kbd_legacy_ctl_tb_top.sv
module kbd_legacy_ctl_tb_top;

  localparam time CLK_P = 10ns;

  logic        clk;
  logic        rst_n;
  logic [7:0]  cfg_addr;
  logic        cfg_we;
  logic [1:0]  cfg_be;
  logic [15:0] cfg_wdata;
  logic [15:0] cfg_rdata;
  logic        io_valid;
  logic        io_write;
  logic [15:0] io_port;
  logic        io_trap;
  logic        usb_irq;
  logic        a20_active;
  logic        a20_end;
  logic        a20_pass_en;
  logic        smi_n;
  logic        pirqd_irq;

  kbd_legacy_ctl dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_addr(cfg_addr), .cfg_we(cfg_we), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .io_valid(io_valid), .io_write(io_write), .io_port(io_port),
    .io_trap(io_trap), .usb_irq(usb_irq), .a20_active(a20_active),
    .a20_end(a20_end), .a20_pass_en(a20_pass_en),
    .smi_n(smi_n), .pirqd_irq(pirqd_irq)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  typedef enum int {K_RDATA, K_SMI, K_PIRQ, K_TRAP, K_A20EN} kind_e;
  typedef struct {
    kind_e       kind;
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t exp_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;

  // monitor: compare every queued expectation at the falling edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = exp_q.pop_front();
      case (it.kind)
        K_RDATA: act = cfg_rdata;
        K_SMI:   act = {15'd0, smi_n};
        K_PIRQ:  act = {15'd0, pirqd_irq};
        K_TRAP:  act = {15'd0, io_trap};
        default: act = {15'd0, a20_pass_en};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_now(kind_e k, logic [15:0] v, string req);
    item_t it;
    it.kind = k; it.exp = v; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic cfg_write(logic [7:0] a, logic [1:0] be, logic [15:0] d);
    cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_we = 1'b1;
    @(posedge clk); #1;
    cfg_we = 1'b0; cfg_addr = 8'hC0;
  endtask

  task automatic io_access(logic [15:0] p, logic wr);
    io_port = p; io_write = wr; io_valid = 1'b1;
    @(posedge clk); #1;
    io_valid = 1'b0;
  endtask

  task automatic read_chk(logic [15:0] v, string req);
    expect_now(K_RDATA, v, req);
    settle();
  endtask

  task automatic trap_chk(logic [15:0] p, logic wr, logic v, string req);
    io_port = p; io_write = wr; io_valid = 1'b1;
    expect_now(K_TRAP, {15'd0, v}, req);
    settle();
    @(posedge clk); #1;
    io_valid = 1'b0;
  endtask

  task automatic bit_chk(kind_e k, logic v, string req);
    expect_now(k, {15'd0, v}, req);
    settle();
  endtask

  initial begin
    rst_n = 1'b0; cfg_addr = 8'hC0; cfg_we = 1'b0; cfg_be = 2'b00; cfg_wdata = '0;
    io_valid = 1'b0; io_write = 1'b0; io_port = '0;
    usb_irq = 1'b0; a20_active = 1'b0; a20_end = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1 reset state
    read_chk(16'h2000, "R1 reset word");
    bit_chk(K_SMI, 1'b1, "R1 smi idle");
    bit_chk(K_PIRQ, 1'b0, "R1 pirq idle");

    // R2 access flags
    io_access(16'h0060, 1'b0);
    read_chk(16'h2100, "R2 read 60h flag");
    io_access(16'h0064, 1'b1);
    read_chk(16'h2900, "R2 write 64h flag");
    io_access(16'h0061, 1'b1);
    read_chk(16'h2900, "R2 other port ignored");
    bit_chk(K_SMI, 1'b1, "R5 flags without enables");

    // R3 write-one-to-clear
    cfg_write(8'hC0, 2'b11, 16'h2100);
    read_chk(16'h2800, "R3 clear bit 8");
    cfg_write(8'hC0, 2'b11, 16'h2000);
    read_chk(16'h2800, "R3 zero keeps flag");

    // R5 / R12 enables
    cfg_write(8'hC0, 2'b11, 16'h2008);
    read_chk(16'h2808, "R5 enable write 64h");
    bit_chk(K_SMI, 1'b0, "R5 enabled flag asserts smi");
    trap_chk(16'h0064, 1'b1, 1'b1, "R12 enabled access traps");
    trap_chk(16'h0060, 1'b0, 1'b0, "R12 disabled access no trap");
    read_chk(16'h2908, "R2 read 60h recorded");
    cfg_write(8'hC0, 2'b11, 16'h2808);
    read_chk(16'h2108, "R3 clear bit 11");
    bit_chk(K_SMI, 1'b1, "R5 smi released");
    cfg_write(8'hC0, 2'b10, 16'h2100);
    read_chk(16'h2008, "R10 high byte only");

    // R4 collision
    io_port = 16'h0060; io_write = 1'b0; io_valid = 1'b1;
    cfg_write(8'hC0, 2'b10, 16'h2100);
    io_valid = 1'b0;
    read_chk(16'h2108, "R4 event wins");
    cfg_write(8'hC0, 2'b10, 16'h2100);
    read_chk(16'h2008, "R3 clear after collision");

    // R10 byte enables
    cfg_write(8'hC0, 2'b01, 16'h0000);
    read_chk(16'h2000, "R10 low byte only");
    cfg_write(8'hC0, 2'b10, 16'h0000);
    read_chk(16'h0000, "R10 routing cleared");

    // R6 / R7 USB interrupt
    usb_irq = 1'b1;
    bit_chk(K_PIRQ, 1'b0, "R7 unrouted");
    read_chk(16'h1000, "R6 live irq bit");
    cfg_write(8'hC0, 2'b11, 16'h2000);
    bit_chk(K_PIRQ, 1'b1, "R7 routed");
    bit_chk(K_SMI, 1'b1, "R13 0x2000 no smi");
    read_chk(16'h3000, "R13 0x2000 readback");
    cfg_write(8'hC0, 2'b11, 16'h2010);
    bit_chk(K_SMI, 1'b0, "R6 usb smi");
    cfg_write(8'hC0, 2'b11, 16'h2000);
    bit_chk(K_SMI, 1'b1, "R6 usb smi off");
    usb_irq = 1'b0;
    bit_chk(K_PIRQ, 1'b0, "R7 follows irq");

    // R9 / R13 all ones
    cfg_write(8'hC0, 2'b11, 16'hFFFF);
    read_chk(16'h20BF, "R9 R13 all ones");
    bit_chk(K_SMI, 1'b1, "R13 no pending sources");
    bit_chk(K_A20EN, 1'b1, "R8 pass enable out");

    // R8 passthrough
    a20_active = 1'b1;
    read_chk(16'h20FF, "R8 busy bit");
    a20_end = 1'b1; a20_active = 1'b0;
    @(posedge clk); #1;
    a20_end = 1'b0;
    read_chk(16'hA0BF, "R8 end flag");
    bit_chk(K_SMI, 1'b0, "R8 end smi");
    cfg_write(8'hC0, 2'b10, 16'hA000);
    read_chk(16'h20BF, "R3 clear end flag");
    bit_chk(K_SMI, 1'b1, "R8 smi released");
    cfg_write(8'hC0, 2'b11, 16'h2000);
    a20_end = 1'b1;
    @(posedge clk); #1;
    a20_end = 1'b0;
    read_chk(16'h2000, "R8 end ignored when disabled");
    bit_chk(K_A20EN, 1'b0, "R8 pass enable off");

    // R11 other offsets
    cfg_write(8'hC4, 2'b11, 16'h0000);
    read_chk(16'h2000, "R11 miss write ignored");
    cfg_addr = 8'hC4;
    read_chk(16'h0000, "R11 miss read zero");
    cfg_addr = 8'hC0;

    settle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule